// File: doc/BRIEF.md
# Serial Row/Column Packet Decoder

This block receives a serial byte stream from a host controller over a three-wire link (active-low select, serial clock, serial data) and turns it into write strobes for an on-screen character memory. Bits are captured MSB first on rising serial-clock edges while select is low. The link pins are oversampled by the system clock through synchronizer stages, so the decoder runs entirely in the system clock domain.

Every complete byte is classified as a row byte, a column byte or a data byte. A row byte picks one of three targets: the display character-code plane, the display attribute plane or the user glyph RAM. It also loads a row number. A column byte loads a column number and chooses between addressed transfers and streaming transfers. In addressed mode the stream is either row-column-data repeated or column-data repeated after one row, and the two mix freely. In streaming mode every later byte is data, and the column steps after each write. Raising select at any point abandons the packet and any partial byte.

The decoder is a five-state machine. The states are `ST_IDLE` (wait for a row), `ST_ROW` (row held, wait for a column), `ST_COL` (addressed column held, next byte is data), `ST_DATA` (addressed write done, wait for a row or a column) and `ST_STREAM` (every byte is data). The transitions are:
- `ST_IDLE` goes to `ST_ROW` on a row byte and ignores every other byte.
- `ST_ROW` and `ST_DATA` stay in or go to `ST_ROW` on a row byte. They go to `ST_COL` on a column byte whose mode bit is 0, and to `ST_STREAM` on one whose mode bit is 1.
- `ST_COL` goes to `ST_DATA` on any byte.
- `ST_STREAM` stays in `ST_STREAM`.
- Every state goes back to `ST_IDLE` when select is high.

Top module: `osd_serial_decoder`

## Requirements
- R1: Serial data is sampled on each rising serial-clock edge while select is low. The first bit sampled is bit 7 of the byte, and a byte is complete after the eighth edge.
- R2: While select is high, the partial byte count is cleared and the decoder returns to `ST_IDLE`. No write strobe is issued, and the first byte of the next frame is decoded as if it started a new packet.
- R3: In `ST_IDLE`, a byte with bit 7 = 0 is discarded without a write.
- R4: A byte with bit 7 = 1 in `ST_IDLE`, `ST_ROW` or `ST_DATA` is a row byte, decoded as follows:
  - If bit 6 = 1, the target is glyph RAM (`wr_tgt` = 2) and the row is bits 2:0.
  - If bit 6 = 0, the row is bits 3:0 and the target is set by bit 5: 0 selects the code plane (`wr_tgt` = 0) and 1 selects the attribute plane (`wr_tgt` = 1).
- R5: A byte with bit 7 = 0 in `ST_ROW` or `ST_DATA` is a column byte. Its column is bits 4:0 for a display target and bits 5:0 for glyph RAM. With bit 6 = 0, the next byte is written to the held target, row and column.
- R6: After an addressed write, a column byte reuses the held row and target.
- R7: After an addressed write, a row byte replaces the held row and target before the next column.
- R8: A column byte with bit 6 = 1 enters `ST_STREAM`. Every later byte of that frame is written as data, even one with bit 7 = 1, and the decoder never leaves streaming until select rises.
- R9: In streaming mode the column steps by one after each write. For display targets, column 31 wraps to 0 and advances the row, and row 15 wraps to 0.
- R10: For glyph RAM in streaming mode, column 35 wraps to 0 and advances the row, and row 7 wraps to 0.
- R11: A glyph RAM write to column 36 or above is discarded, with no strobe. The packet sequencing still advances.
- R12: `wr_en` is low after reset and is a one-cycle pulse per accepted data byte. `wr_data` carries the byte, and `wr_tgt`, `wr_row` and `wr_col` carry its address in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sel_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| wr_en | output | 1 | One-cycle write strobe |
| wr_tgt | output | 2 | Write target: 0 code plane, 1 attribute plane, 2 glyph RAM |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 6 | Column of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
A write strobe appears four system clock cycles after the eighth rising serial-clock edge of its byte. Two cycles go to synchronization, one to edge detection and shifting, and one to the registered decoder outputs. The serial clock runs with eight system cycles per half period, so each strobe lands well before the next byte completes. The driver pushes the expected write for each data byte into a queue. A monitor compares every strobe it sees on a falling clock edge against the head of that queue. After each frame the bench waits out that latency plus margin and checks that the queue is empty, which catches writes that should have appeared but did not. Discarded bytes push nothing, so any strobe they cause is reported as unexpected.

// File: rtl/osd_serial_pkg.sv
package osd_serial_pkg;

    typedef enum logic [1:0] {
        TGT_CODE = 2'd0,
        TGT_ATTR = 2'd1,
        TGT_FONT = 2'd2
    } wr_tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ROW    = 3'd1,
        ST_COL    = 3'd2,
        ST_DATA   = 3'd3,
        ST_STREAM = 3'd4
    } pkt_st_e;

endpackage

// File: rtl/osd_spi_rx.sv
module osd_spi_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              frame_act,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [SYNC_STAGES-1:0] sck_s;
    logic [SYNC_STAGES-1:0] sel_s;
    logic [SYNC_STAGES-1:0] sdi_s;
    logic                   sck_d;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-2:0]      shreg;
    logic                   sck_rise;

    // synchronizer chains, stage 0 takes the pin
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_s[0] <= 1'b0;
                    sel_s[0] <= 1'b1;
                    sdi_s[0] <= 1'b0;
                end else begin
                    sck_s[0] <= sck;
                    sel_s[0] <= sel_n;
                    sdi_s[0] <= sdi;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_s[i] <= 1'b0;
                    sel_s[i] <= 1'b1;
                    sdi_s[i] <= 1'b0;
                end else begin
                    sck_s[i] <= sck_s[i-1];
                    sel_s[i] <= sel_s[i-1];
                    sdi_s[i] <= sdi_s[i-1];
                end
            end
        end
    end

    assign frame_act = ~sel_s[SYNC_STAGES-1];
    assign sck_rise  = sck_s[SYNC_STAGES-1] & ~sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            sck_d    <= sck_s[SYNC_STAGES-1];
            byte_vld <= 1'b0;
            if (!frame_act) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                if (bit_cnt == LAST_BIT) begin
                    byte_out <= {shreg, sdi_s[SYNC_STAGES-1]};
                    byte_vld <= 1'b1;
                    bit_cnt  <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-3:0], sdi_s[SYNC_STAGES-1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_addr_step.sv
module osd_addr_step #(
    parameter int DISP_ROW_W = 4,
    parameter int DISP_COL_W = 5,
    parameter int FONT_ROW_W = 3,
    parameter int FONT_COL_W = 6,
    parameter int FONT_COLS  = 36,
    localparam int ROW_W = (DISP_ROW_W > FONT_ROW_W) ? DISP_ROW_W : FONT_ROW_W,
    localparam int COL_W = (DISP_COL_W > FONT_COL_W) ? DISP_COL_W : FONT_COL_W
) (
    input  logic             is_font,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row_nx,
    output logic [COL_W-1:0] col_nx,
    output logic             in_range
);
    localparam logic [COL_W-1:0] DISP_LAST_COL = COL_W'((1 << DISP_COL_W) - 1);
    localparam logic [COL_W-1:0] FONT_LAST_COL = COL_W'(FONT_COLS - 1);
    localparam logic [COL_W-1:0] FONT_LIMIT    = COL_W'(FONT_COLS);
    localparam logic [ROW_W-1:0] DISP_LAST_ROW = ROW_W'((1 << DISP_ROW_W) - 1);
    localparam logic [ROW_W-1:0] FONT_LAST_ROW = ROW_W'((1 << FONT_ROW_W) - 1);

    logic [COL_W-1:0] last_col;
    logic [ROW_W-1:0] last_row;
    logic             wrap;

    always_comb begin
        last_col = is_font ? FONT_LAST_COL : DISP_LAST_COL;
        last_row = is_font ? FONT_LAST_ROW : DISP_LAST_ROW;
        wrap     = (col >= last_col);
        col_nx   = wrap ? '0 : col + 1'b1;
        if (!wrap)
            row_nx = row;
        else if (row >= last_row)
            row_nx = '0;
        else
            row_nx = row + 1'b1;
        in_range = is_font ? (col < FONT_LIMIT) : 1'b1;
    end
endmodule

// File: rtl/osd_pkt_fsm.sv
module osd_pkt_fsm
    import osd_serial_pkg::*;
#(
    parameter int DISP_ROW_W = 4,
    parameter int DISP_COL_W = 5,
    parameter int FONT_ROW_W = 3,
    parameter int FONT_COL_W = 6,
    parameter int FONT_COLS  = 36,
    localparam int ROW_W = (DISP_ROW_W > FONT_ROW_W) ? DISP_ROW_W : FONT_ROW_W,
    localparam int COL_W = (DISP_COL_W > FONT_COL_W) ? DISP_COL_W : FONT_COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_act,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    output pkt_st_e          st,
    output logic             wr_en,
    output logic [1:0]       wr_tgt,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data
);
    pkt_st_e          st_nx;
    wr_tgt_e          tgt_q, tgt_nx;
    logic [ROW_W-1:0] row_q, row_nx;
    logic [COL_W-1:0] col_q, col_nx;
    logic             fire;
    logic [ROW_W-1:0] step_row;
    logic [COL_W-1:0] step_col;
    logic             in_range;
    logic             is_row_byte;
    logic             mode_bit;

    osd_addr_step #(
        .DISP_ROW_W(DISP_ROW_W), .DISP_COL_W(DISP_COL_W),
        .FONT_ROW_W(FONT_ROW_W), .FONT_COL_W(FONT_COL_W),
        .FONT_COLS (FONT_COLS)
    ) u_step (
        .is_font (tgt_q == TGT_FONT),
        .row     (row_q),
        .col     (col_q),
        .row_nx  (step_row),
        .col_nx  (step_col),
        .in_range(in_range)
    );

    assign is_row_byte = byte_in[7];
    assign mode_bit    = byte_in[6];

    // next state and held address
    always_comb begin
        st_nx  = st;
        tgt_nx = tgt_q;
        row_nx = row_q;
        col_nx = col_q;
        fire   = 1'b0;
        if (byte_vld) begin
            unique case (st)
                ST_IDLE, ST_ROW, ST_DATA: begin
                    if (is_row_byte) begin
                        st_nx = ST_ROW;
                        if (mode_bit) begin
                            tgt_nx = TGT_FONT;
                            row_nx = ROW_W'(byte_in[FONT_ROW_W-1:0]);
                        end else begin
                            tgt_nx = byte_in[5] ? TGT_ATTR : TGT_CODE;
                            row_nx = ROW_W'(byte_in[DISP_ROW_W-1:0]);
                        end
                    end else if (st != ST_IDLE) begin
                        st_nx  = mode_bit ? ST_STREAM : ST_COL;
                        col_nx = (tgt_q == TGT_FONT) ? COL_W'(byte_in[FONT_COL_W-1:0])
                                                     : COL_W'(byte_in[DISP_COL_W-1:0]);
                    end
                end
                ST_COL: begin
                    fire  = in_range;
                    st_nx = ST_DATA;
                end
                ST_STREAM: begin
                    fire   = in_range;
                    row_nx = step_row;
                    col_nx = step_col;
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            tgt_q <= TGT_CODE;
            row_q <= '0;
            col_q <= '0;
        end else if (!frame_act) begin
            st <= ST_IDLE;
        end else begin
            st    <= st_nx;
            tgt_q <= tgt_nx;
            row_q <= row_nx;
            col_q <= col_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_tgt  <= TGT_CODE;
            wr_row  <= '0;
            wr_col  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= fire && frame_act;
            if (fire && frame_act) begin
                wr_tgt  <= tgt_q;
                wr_row  <= row_q;
                wr_col  <= col_q;
                wr_data <= byte_in;
            end
        end
    end
endmodule

// File: rtl/osd_serial_decoder.sv
module osd_serial_decoder
    import osd_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DISP_ROW_W  = 4,
    parameter int DISP_COL_W  = 5,
    parameter int FONT_ROW_W  = 3,
    parameter int FONT_COL_W  = 6,
    parameter int FONT_COLS   = 36,
    localparam int ROW_W = (DISP_ROW_W > FONT_ROW_W) ? DISP_ROW_W : FONT_ROW_W,
    localparam int COL_W = (DISP_COL_W > FONT_COL_W) ? DISP_COL_W : FONT_COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sel_n,
    input  logic             spi_sck,
    input  logic             spi_sdi,
    output logic             wr_en,
    output logic [1:0]       wr_tgt,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] wr_col,
    output logic [7:0]       wr_data
);
    logic       frame_act;
    logic       byte_vld;
    logic [7:0] byte_val;
    pkt_st_e    pkt_st;

    osd_spi_rx #(
        .SYNC_STAGES(SYNC_STAGES),
        .BYTE_W     (8)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (spi_sel_n),
        .sck      (spi_sck),
        .sdi      (spi_sdi),
        .frame_act(frame_act),
        .byte_vld (byte_vld),
        .byte_out (byte_val)
    );

    osd_pkt_fsm #(
        .DISP_ROW_W(DISP_ROW_W), .DISP_COL_W(DISP_COL_W),
        .FONT_ROW_W(FONT_ROW_W), .FONT_COL_W(FONT_COL_W),
        .FONT_COLS (FONT_COLS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_act(frame_act),
        .byte_vld (byte_vld),
        .byte_in  (byte_val),
        .st       (pkt_st),
        .wr_en    (wr_en),
        .wr_tgt   (wr_tgt),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data)
    );
endmodule

// File: rtl/osd_serial_decoder_chk.sv
module osd_serial_decoder_chk
    import osd_serial_pkg::*;
#(
    parameter int ROW_W      = 4,
    parameter int COL_W      = 6,
    parameter int DISP_COL_W = 5,
    parameter int FONT_ROW_W = 3,
    parameter int FONT_COLS  = 36
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_act,
    input pkt_st_e          pkt_st,
    input logic             wr_en,
    input logic [1:0]       wr_tgt,
    input logic [ROW_W-1:0] wr_row,
    input logic [COL_W-1:0] wr_col
);
    localparam logic [COL_W-1:0] FONT_LIMIT = COL_W'(FONT_COLS);
    localparam logic [COL_W-1:0] DISP_LIMIT = COL_W'(1 << DISP_COL_W);
    localparam logic [ROW_W-1:0] FROW_LIMIT = ROW_W'(1 << FONT_ROW_W);

    assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_select_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> (!wr_en && pkt_st == ST_IDLE));

    assert_stream_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_st == ST_STREAM && frame_act) |=> pkt_st == ST_STREAM);

    assert_font_col_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_FONT) |-> wr_col < FONT_LIMIT);

    assert_disp_col_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt != TGT_FONT) |-> wr_col < DISP_LIMIT);

    assert_font_row_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == TGT_FONT) |-> wr_row < FROW_LIMIT);

    assert_target_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_tgt != 2'd3);
endmodule

bind osd_serial_decoder osd_serial_decoder_chk #(
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .DISP_COL_W(DISP_COL_W),
    .FONT_ROW_W(FONT_ROW_W),
    .FONT_COLS (FONT_COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_act(frame_act),
    .pkt_st   (pkt_st),
    .wr_en    (wr_en),
    .wr_tgt   (wr_tgt),
    .wr_row   (wr_row),
    .wr_col   (wr_col)
);

// File: tb/osd_serial_decoder_test.sv
module osd_serial_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       wr_en;
    logic [1:0] wr_tgt;
    logic [3:0] wr_row;
    logic [5:0] wr_col;
    logic [7:0] wr_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  prev_en = 1'b0;

    typedef struct packed {
        logic [1:0] tgt;
        logic [3:0] row;
        logic [5:0] col;
        logic [7:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    osd_serial_decoder uut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_sck(sck), .spi_sdi(sdi),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    task automatic expect_wr(input logic [1:0] t, input logic [3:0] r,
                             input logic [5:0] c, input logic [7:0] d, input string tag);
        exp_q.push_back({t, r, c, d});
        tag_q.push_back(tag);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdi = b[i];
            repeat (8) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic frame_start();
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_stop(input string tag);
        repeat (12) @(negedge clk);
        sel_n = 1'b1;
        repeat (12) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL %s: missing writes, actual pending=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            exp_t  e;
            string tg;
            total++;
            if (prev_en) begin
                bad++;
                $display("FAIL R12: strobe longer than one cycle, actual=1 expected=0");
            end
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R3/R11: unexpected write actual tgt=%0d row=%0d col=%0d data=%02h expected=none",
                         wr_tgt, wr_row, wr_col, wr_data);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if ({wr_tgt, wr_row, wr_col, wr_data} !== e) begin
                    bad++;
                    $display("FAIL %s: actual tgt=%0d row=%0d col=%0d data=%02h expected tgt=%0d row=%0d col=%0d data=%02h",
                             tg, wr_tgt, wr_row, wr_col, wr_data, e.tgt, e.row, e.col, e.data);
                end
            end
        end
        prev_en <= wr_en;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        total++;
        if (wr_en !== 1'b0) begin
            bad++;
            $display("FAIL R12: reset strobe actual=%b expected=0", wr_en);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: stray byte in idle, then packet; R1 MSB first on asymmetric data
        frame_start();
        send_byte(8'h05);
        send_byte(8'h80);
        send_byte(8'h03);
        expect_wr(2'd0, 4'd0, 6'd3, 8'h41, "R1/R3");
        send_byte(8'h41);
        frame_stop("R3");

        // R4/R5 attribute plane
        frame_start();
        send_byte(8'hA7);
        send_byte(8'h1F);
        expect_wr(2'd1, 4'd7, 6'd31, 8'h3C, "R4/R5 attr");
        send_byte(8'h3C);
        frame_stop("R4");

        // R4/R5 font RAM, 6-bit column
        frame_start();
        send_byte(8'hC5);
        send_byte(8'h23);
        expect_wr(2'd2, 4'd5, 6'd35, 8'hE1, "R4/R5 font");
        send_byte(8'hE1);
        frame_stop("R5");

        // R6 column-data repeats
        frame_start();
        send_byte(8'h82);
        send_byte(8'h01);
        expect_wr(2'd0, 4'd2, 6'd1, 8'h11, "R6");
        send_byte(8'h11);
        send_byte(8'h02);
        expect_wr(2'd0, 4'd2, 6'd2, 8'h22, "R6");
        send_byte(8'h22);
        frame_stop("R6");

        // R7 row-column-data repeats
        frame_start();
        send_byte(8'h83);
        send_byte(8'h04);
        expect_wr(2'd0, 4'd3, 6'd4, 8'hAA, "R7");
        send_byte(8'hAA);
        send_byte(8'hA9);
        send_byte(8'h05);
        expect_wr(2'd1, 4'd9, 6'd5, 8'hBB, "R7");
        send_byte(8'hBB);
        frame_stop("R7");

        // R8/R9 streaming display, row-byte-looking data, column wrap
        frame_start();
        send_byte(8'h8E);
        send_byte(8'h5E);
        expect_wr(2'd0, 4'd14, 6'd30, 8'h81, "R8");
        send_byte(8'h81);
        expect_wr(2'd0, 4'd14, 6'd31, 8'h92, "R9");
        send_byte(8'h92);
        expect_wr(2'd0, 4'd15, 6'd0, 8'h03, "R9");
        send_byte(8'h03);
        frame_stop("R8");

        // R9 row 15 wraps to row 0
        frame_start();
        send_byte(8'hAF);
        send_byte(8'h5F);
        expect_wr(2'd1, 4'd15, 6'd31, 8'h10, "R9");
        send_byte(8'h10);
        expect_wr(2'd1, 4'd0, 6'd0, 8'h20, "R9 row wrap");
        send_byte(8'h20);
        frame_stop("R9");

        // R10 font streaming wrap at 35 and row 7
        frame_start();
        send_byte(8'hC7);
        send_byte(8'h62);
        expect_wr(2'd2, 4'd7, 6'd34, 8'h01, "R10");
        send_byte(8'h01);
        expect_wr(2'd2, 4'd7, 6'd35, 8'h02, "R10");
        send_byte(8'h02);
        expect_wr(2'd2, 4'd0, 6'd0, 8'h03, "R10 row wrap");
        send_byte(8'h03);
        frame_stop("R10");

        // R11 out-of-range font column discarded, sequencing continues
        frame_start();
        send_byte(8'hC1);
        send_byte(8'h28);
        send_byte(8'h55);
        send_byte(8'h00);
        expect_wr(2'd2, 4'd1, 6'd0, 8'h66, "R11");
        send_byte(8'h66);
        frame_stop("R11");

        // R2 abort mid-byte, then fresh frame starts in idle
        frame_start();
        send_byte(8'h84);
        send_byte(8'h02);
        send_bits(8'hF0, 4);
        frame_stop("R2 abort");
        frame_start();
        send_byte(8'h55);
        send_byte(8'h81);
        send_byte(8'h01);
        expect_wr(2'd0, 4'd1, 6'd1, 8'h77, "R2");
        send_byte(8'h77);
        frame_stop("R2");

        // R3 frame of only non-row bytes
        frame_start();
        send_byte(8'h00);
        send_byte(8'h7F);
        frame_stop("R3 idle");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule